// File: doc/BRIEF.md
# Return Address Prediction Stack

This block supplies predicted targets for subroutine return branches in a branch unit. It keeps a small circular stack of return addresses and, next to it, a shadow copy of the link register with a flag that says whether that copy is current. A call (branch-and-link) writes its return address into both the stack and the shadow link register. A move to the link register marks the shadow invalid when it issues. The shadow becomes valid again when the real value is forwarded at write-back.

When a return branch arrives, the block predicts its target one cycle later. It uses the shadow link register if that copy is valid. If the link register is still pending, it uses the top of the stack. If the link register is pending and the stack is empty, it asks the branch to stall. Every return pops one stack entry.

A prediction taken from the stack stays outstanding until the real link register value is forwarded. The branch then resolves on the following cycle. If the stack guess was wrong, a mispredict pulse carries the correct target.

Top module: `ret_addr_predictor`

## Requirements
- R1: A cycle with `call_valid` high pushes `call_ret_addr` onto the stack and makes the shadow link register valid, holding that address.
- R2: A return (`ret_valid`) seen while the shadow link register is valid gives, on the next cycle, `pred_valid`=1, `pred_target` = the shadow value and `pred_from_stack`=0.
- R3: A return seen while the link register is pending and the stack is not empty gives, on the next cycle, `pred_valid`=1, `pred_target` = the stack top and `pred_from_stack`=1.
- R4: Every return pops one entry if the stack is not empty, whichever source it predicts from. Entries come back last-in first-out, so two calls followed by two returns leave the stack empty.
- R5: A return seen while the link register is pending and the stack is empty gives, on the next cycle, `ret_stall`=1 and `pred_valid`=0.
- R6: `mtlr_issue` marks the link register pending. A forwarded value (`lr_fwd_valid`) writes the shadow and marks it valid. When these coincide with each other or with a call, the issue wins over the forward, and the forward wins over the call.
- R7: A forwarded value that arrives while a stack prediction is outstanding, or in the same cycle as a new one, gives `resolve_valid`=1 on the next cycle, with `correct_target` = the forwarded value. `mispredict` is 1 exactly when that value differs from the predicted target. A forward with no stack prediction outstanding resolves nothing.
- R8: Pushing onto a full stack overwrites its oldest entry. Later pops return the newest DEPTH addresses, and the stack is then empty.
- R9: A call and a return in the same cycle with a non-empty stack replace the top entry: the return reads the old top, and the number of entries stays the same.
- R10: A synchronous reset (`rst` high) empties the stack, marks the link register pending, clears any outstanding prediction and drives every output to zero.
- R11: Outside the cycle after a return or a resolution, the prediction outputs and the resolution outputs, targets included, read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_valid | input | 1 | A branch-and-link executes this cycle |
| call_ret_addr | input | AW | Return address of that call |
| mtlr_issue | input | 1 | A move-to-link-register issues this cycle |
| lr_fwd_valid | input | 1 | The real link register value is forwarded this cycle |
| lr_fwd_value | input | AW | The forwarded link register value |
| ret_valid | input | 1 | A return-through-link-register branch arrives |
| pred_valid | output | 1 | A predicted target is presented |
| pred_target | output | AW | Predicted return target |
| pred_from_stack | output | 1 | The prediction came from the stack |
| ret_stall | output | 1 | No prediction is possible; the return must wait |
| resolve_valid | output | 1 | An outstanding stack prediction resolves |
| mispredict | output | 1 | The resolved prediction was wrong |
| correct_target | output | AW | Forwarded target at resolution |

## Verification
The bench builds the block with DEPTH=4 and AW=16. A depth of four makes the overwrite of the oldest entry, and the drain that follows, reachable within a handful of calls. The narrow addresses keep the expected-value table readable, while still exercising equal and differing targets at resolution.

// File: rtl/rap_pkg.sv
package rap_pkg;

  // Where a return prediction came from
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_LR    = 2'd1,
    SRC_STACK = 2'd2
  } pred_src_e;

endpackage

// File: rtl/rap_stack.sv
module rap_stack #(
  parameter int DEPTH = 8,
  parameter int AW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic          pop,
  output logic [AW-1:0] top_addr,
  output logic          empty
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr;
  logic [CW-1:0] count;
  logic [PW-1:0] top_idx;
  logic [PW-1:0] nxt_idx;
  logic [PW-1:0] wr_idx;
  logic          do_pop;

  assign top_idx = (wr_ptr == '0) ? LAST_IDX : wr_ptr - 1'b1;
  assign nxt_idx = (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
  assign do_pop  = pop && (count != '0);
  // a push that meets a pop lands on the slot the pop just read
  assign wr_idx  = do_pop ? top_idx : wr_ptr;

  // single write port, no reset: suits block or distributed RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_idx] <= push_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      unique case ({push, do_pop})
        2'b10: begin
          wr_ptr <= nxt_idx;
          if (count != FULL_CNT) count <= count + 1'b1;
        end
        2'b01: begin
          wr_ptr <= top_idx;
          count  <= count - 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign top_addr = mem[top_idx];
  assign empty    = (count == '0);

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT); // R8
  AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && count == '0) |=> (count == '0)); // R4
  AST_SWAP_KEEPS_DEPTH: assert property (@(posedge clk) disable iff (rst)
    (push && pop && count != '0) |=> (count == $past(count))); // R9
  AST_RESET_EMPTIES: assert property (@(posedge clk)
    rst |=> (count == '0)); // R10

endmodule

// File: rtl/rap_lr_track.sv
module rap_lr_track #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mtlr_issue,
  input  logic          fwd_valid,
  input  logic [AW-1:0] fwd_value,
  input  logic          call_valid,
  input  logic [AW-1:0] call_addr,
  output logic          lr_valid,
  output logic [AW-1:0] lr_value
);

  always_ff @(posedge clk) begin
    if (rst) begin
      lr_valid <= 1'b0;
      lr_value <= '0;
    end else if (mtlr_issue) begin
      lr_valid <= 1'b0;
    end else if (fwd_valid) begin
      lr_valid <= 1'b1;
      lr_value <= fwd_value;
    end else if (call_valid) begin
      lr_valid <= 1'b1;
      lr_value <= call_addr;
    end
  end

  AST_ISSUE_INVALIDATES: assert property (@(posedge clk) disable iff (rst)
    mtlr_issue |=> !lr_valid); // R6
  AST_CALL_WRITES_LR: assert property (@(posedge clk) disable iff (rst)
    (call_valid && !mtlr_issue && !fwd_valid) |=>
      (lr_valid && lr_value == $past(call_addr))); // R1

endmodule

// File: rtl/rap_resolve.sv
module rap_resolve #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          spec_valid,
  input  logic [AW-1:0] spec_target,
  input  logic          fwd_valid,
  input  logic [AW-1:0] fwd_value,
  output logic          resolve_valid,
  output logic          mispredict,
  output logic [AW-1:0] correct_target
);

  logic          held_valid;
  logic [AW-1:0] held_target;
  logic          res_now;
  logic [AW-1:0] cmp_target;

  // a prediction made in the same cycle takes precedence over an older one
  assign cmp_target = spec_valid ? spec_target : held_target;
  assign res_now    = fwd_valid && (spec_valid || held_valid);

  always_ff @(posedge clk) begin
    if (rst) begin
      held_valid     <= 1'b0;
      held_target    <= '0;
      resolve_valid  <= 1'b0;
      mispredict     <= 1'b0;
      correct_target <= '0;
    end else begin
      resolve_valid  <= res_now;
      mispredict     <= res_now && (cmp_target != fwd_value);
      correct_target <= res_now ? fwd_value : '0;
      if (fwd_valid) begin
        held_valid <= 1'b0;
      end else if (spec_valid) begin
        held_valid  <= 1'b1;
        held_target <= spec_target;
      end
    end
  end

  AST_MISP_WITH_RESOLVE: assert property (@(posedge clk) disable iff (rst)
    mispredict |-> resolve_valid); // R7
  AST_RESOLVE_AFTER_FWD: assert property (@(posedge clk) disable iff (rst)
    resolve_valid |-> $past(fwd_valid)); // R7

endmodule

// File: rtl/ret_addr_predictor.sv
module ret_addr_predictor #(
  parameter int DEPTH = 8,
  parameter int AW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          call_valid,
  input  logic [AW-1:0] call_ret_addr,
  input  logic          mtlr_issue,
  input  logic          lr_fwd_valid,
  input  logic [AW-1:0] lr_fwd_value,
  input  logic          ret_valid,
  output logic          pred_valid,
  output logic [AW-1:0] pred_target,
  output logic          pred_from_stack,
  output logic          ret_stall,
  output logic          resolve_valid,
  output logic          mispredict,
  output logic [AW-1:0] correct_target
);
  import rap_pkg::*;

  logic          lr_valid;
  logic [AW-1:0] lr_value;
  logic [AW-1:0] stk_top;
  logic          stk_empty;
  pred_src_e     src;
  logic          spec_now;

  rap_stack #(.DEPTH(DEPTH), .AW(AW)) u_stack (
    .clk      (clk),
    .rst      (rst),
    .push     (call_valid),
    .push_addr(call_ret_addr),
    .pop      (ret_valid),
    .top_addr (stk_top),
    .empty    (stk_empty)
  );

  rap_lr_track #(.AW(AW)) u_lr (
    .clk       (clk),
    .rst       (rst),
    .mtlr_issue(mtlr_issue),
    .fwd_valid (lr_fwd_valid),
    .fwd_value (lr_fwd_value),
    .call_valid(call_valid),
    .call_addr (call_ret_addr),
    .lr_valid  (lr_valid),
    .lr_value  (lr_value)
  );

  always_comb begin
    if (!ret_valid)     src = SRC_NONE;
    else if (lr_valid)  src = SRC_LR;
    else if (!stk_empty) src = SRC_STACK;
    else                src = SRC_NONE;
  end

  assign spec_now = (src == SRC_STACK);

  rap_resolve #(.AW(AW)) u_res (
    .clk           (clk),
    .rst           (rst),
    .spec_valid    (spec_now),
    .spec_target   (stk_top),
    .fwd_valid     (lr_fwd_valid),
    .fwd_value     (lr_fwd_value),
    .resolve_valid (resolve_valid),
    .mispredict    (mispredict),
    .correct_target(correct_target)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid      <= 1'b0;
      pred_target     <= '0;
      pred_from_stack <= 1'b0;
      ret_stall       <= 1'b0;
    end else begin
      pred_valid      <= (src != SRC_NONE);
      pred_from_stack <= (src == SRC_STACK);
      ret_stall       <= ret_valid && (src == SRC_NONE);
      unique case (src)
        SRC_LR:    pred_target <= lr_value;
        SRC_STACK: pred_target <= stk_top;
        default:   pred_target <= '0;
      endcase
    end
  end

  AST_STALL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    ret_stall |-> !pred_valid); // R5
  AST_PRED_NEEDS_RET: assert property (@(posedge clk) disable iff (rst)
    pred_valid |-> $past(ret_valid)); // R2
  AST_LR_SOURCE_VALUE: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && lr_valid) |=> (pred_valid && !pred_from_stack &&
                                 pred_target == $past(lr_value))); // R2
  AST_STACK_ONLY_PENDING: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && pred_from_stack) |-> !$past(lr_valid)); // R3

endmodule

// File: tb/sim_ret_addr_predictor.sv
module sim_ret_addr_predictor;

  localparam int DEPTH = 4;
  localparam int AW    = 16;
  localparam int OW    = 2 * AW + 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          call_valid = 1'b0;
  logic [AW-1:0] call_ret_addr = '0;
  logic          mtlr_issue = 1'b0;
  logic          lr_fwd_valid = 1'b0;
  logic [AW-1:0] lr_fwd_value = '0;
  logic          ret_valid = 1'b0;
  logic          pred_valid, pred_from_stack, ret_stall;
  logic          resolve_valid, mispredict;
  logic [AW-1:0] pred_target, correct_target;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  ret_addr_predictor #(.DEPTH(DEPTH), .AW(AW)) u0 (
    .clk(clk), .rst(rst),
    .call_valid(call_valid), .call_ret_addr(call_ret_addr),
    .mtlr_issue(mtlr_issue),
    .lr_fwd_valid(lr_fwd_valid), .lr_fwd_value(lr_fwd_value),
    .ret_valid(ret_valid),
    .pred_valid(pred_valid), .pred_target(pred_target),
    .pred_from_stack(pred_from_stack), .ret_stall(ret_stall),
    .resolve_valid(resolve_valid), .mispredict(mispredict),
    .correct_target(correct_target)
  );

  typedef struct packed {
    logic          call;
    logic [AW-1:0] ca;
    logic          iss;
    logic          fwd;
    logic [AW-1:0] fv;
    logic          ret;
    logic [OW-1:0] exp;
  } vec_t;

  // expected output word: {pv, target, from_stack, stall, resolve, misp, correct}
  function automatic logic [OW-1:0] ow(logic pv, logic [AW-1:0] t, logic fs,
                                       logic st, logic rv, logic mp,
                                       logic [AW-1:0] ct);
    return {pv, t, fs, st, rv, mp, ct};
  endfunction

  function automatic vec_t mk(logic c, logic [AW-1:0] ca, logic i, logic f,
                              logic [AW-1:0] fv, logic r, logic [OW-1:0] e);
    return '{call: c, ca: ca, iss: i, fwd: f, fv: fv, ret: r, exp: e};
  endfunction

  localparam logic [OW-1:0] IDLE = '0;
  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    mk(1, 16'h0100, 0, 0, 0, 0, IDLE),                                // R1
    mk(1, 16'h0200, 0, 0, 0, 0, IDLE),                                // R1
    mk(0, 0, 0, 0, 0, 1, ow(1, 16'h0200, 0, 0, 0, 0, 0)),             // R2
    mk(0, 0, 1, 0, 0, 0, IDLE),                                       // R6
    mk(0, 0, 0, 0, 0, 1, ow(1, 16'h0100, 1, 0, 0, 0, 0)),             // R3 R4
    mk(0, 0, 0, 1, 16'h0100, 0, ow(0, 0, 0, 0, 1, 0, 16'h0100)),      // R7
    mk(0, 0, 1, 0, 0, 0, IDLE),                                       // R6
    mk(0, 0, 0, 0, 0, 1, ow(0, 0, 0, 1, 0, 0, 0)),                    // R4 R5
    mk(0, 0, 0, 1, 16'h0300, 0, IDLE),                                // R7 R11
    mk(1, 16'h0400, 0, 0, 0, 0, IDLE),                                // R1
    mk(0, 0, 1, 0, 0, 0, IDLE),                                       // R6
    mk(0, 0, 0, 0, 0, 1, ow(1, 16'h0400, 1, 0, 0, 0, 0)),             // R3
    mk(0, 0, 0, 1, 16'h0404, 0, ow(0, 0, 0, 0, 1, 1, 16'h0404)),      // R7
    mk(0, 0, 0, 0, 0, 1, ow(1, 16'h0404, 0, 0, 0, 0, 0))              // R2 R4
  };

  function automatic logic [OW-1:0] obs();
    return {pred_valid, pred_target, pred_from_stack, ret_stall,
            resolve_valid, mispredict, correct_target};
  endfunction

  task automatic check(string tag, logic [OW-1:0] exp);
    n_checks++;
    if (obs() !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, obs(), exp);
    end
  endtask

  // drive one cycle of stimulus, then look at the registered outputs
  task automatic drive(logic c, logic [AW-1:0] ca, logic i, logic f,
                       logic [AW-1:0] fv, logic r);
    @(negedge clk);
    call_valid = c; call_ret_addr = ca; mtlr_issue = i;
    lr_fwd_valid = f; lr_fwd_value = fv; ret_valid = r;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    call_valid = 0; mtlr_issue = 0; lr_fwd_valid = 0; ret_valid = 0;
    @(posedge clk);
    #1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R10: reset state
    do_reset();
    check("R10 outputs after reset", IDLE);

    foreach (VEC[k]) begin
      drive(VEC[k].call, VEC[k].ca, VEC[k].iss, VEC[k].fwd, VEC[k].fv, VEC[k].ret);
      check($sformatf("table row %0d", k), VEC[k].exp);
    end
    drive(0, 0, 0, 0, 0, 0);
    check("R11 idle after table", IDLE);

    // R10: reset empties the stack and invalidates the link register
    drive(1, 16'h0011, 0, 0, 0, 0);
    drive(1, 16'h0022, 0, 0, 0, 0);
    do_reset();
    drive(0, 0, 0, 0, 0, 1);
    check("R10 stall after reset", ow(0, 0, 0, 1, 0, 0, 0));

    // R8: overflow overwrites the oldest entry
    do_reset();
    for (int a = 1; a <= DEPTH + 1; a++) drive(1, AW'(a), 0, 0, 0, 0);
    drive(0, 0, 1, 0, 0, 0);
    for (int a = DEPTH + 1; a >= 2; a--) begin
      drive(0, 0, 0, 0, 0, 1);
      check("R8 drain newest first", ow(1, AW'(a), 1, 0, 0, 0, 0));
    end
    drive(0, 0, 0, 0, 0, 1);
    check("R8 oldest was overwritten", ow(0, 0, 0, 1, 0, 0, 0));

    // R9: push and pop in one cycle replace the top
    do_reset();
    drive(1, 16'h000A, 0, 0, 0, 0);
    drive(1, 16'h000B, 0, 0, 0, 0);
    drive(1, 16'h000C, 0, 0, 0, 1);
    check("R9 swap predicts from link register", ow(1, 16'h000B, 0, 0, 0, 0, 0));
    drive(0, 0, 1, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 1);
    check("R9 new top after swap", ow(1, 16'h000C, 1, 0, 0, 0, 0));
    drive(0, 0, 0, 0, 0, 1);
    check("R9 depth unchanged", ow(1, 16'h000A, 1, 0, 0, 0, 0));
    drive(0, 0, 0, 0, 0, 1);
    check("R9 then empty", ow(0, 0, 0, 1, 0, 0, 0));

    // R6: priorities between issue, forward and call
    do_reset();
    drive(0, 0, 1, 1, 16'h0077, 0);
    drive(0, 0, 0, 0, 0, 1);
    check("R6 issue beats forward", ow(0, 0, 0, 1, 0, 0, 0));
    drive(1, 16'h0088, 0, 1, 16'h0099, 0);
    drive(0, 0, 0, 0, 0, 1);
    check("R6 forward beats call", ow(1, 16'h0099, 0, 0, 0, 0, 0));

    // R7: forward in the same cycle as a stack prediction
    do_reset();
    drive(1, 16'h0050, 0, 0, 0, 0);
    drive(0, 0, 1, 0, 0, 0);
    drive(0, 0, 0, 1, 16'h0051, 1);
    check("R7 same-cycle resolve", ow(1, 16'h0050, 1, 0, 1, 1, 16'h0051));
    drive(0, 0, 0, 0, 0, 0);
    check("R11 pulse ends", IDLE);

    finish_run();
  end

endmodule